// File: doc/BRIEF.md
# Oversampled Serial Receiver with Majority Voting and Noise Flag

This block receives asynchronous serial frames. A tick input arrives sixteen times per bit period. The block first passes the line through a two-flop synchronizer. It then watches for the falling edge that marks a start bit and counts ticks inside each bit. At the bit's centre it takes three samples and decides the bit's value from the majority of the three. When the three samples of any bit do not all agree, the frame is marked as noisy. The delivered data stays correct as long as only one of the three samples is wrong.

A frame has one low start bit, then eight or nine data bits, least significant first, then one stop bit. A word-length input chooses eight or nine data bits and is captured when the start bit is detected. When the stop-bit decision is made, the block writes the word, a framing-error flag and a noise flag to its outputs and pulses a valid strobe for one cycle. These outputs hold their values until the next strobe. The interrupt output shows the noise flag only while the noise-interrupt enable is high.

The control is a four-state machine:
- **IDLE**: waits for a tick where the previous sample was 1 and the current sample is 0. It then moves to **START**.
- **START**: checks the start bit at its centre. If the vote is 1, the start is treated as a glitch and the machine returns to **IDLE**. Otherwise it moves to **DATA**.
- **DATA**: decides one bit at each bit centre. After the last data bit it moves to **STOP**.
- **STOP**: decides the stop bit, delivers the result and returns to **IDLE** at the stop bit's centre.

Top module: `uart_nrx`

## Requirements
- R1: After reset, data_o is 0, and valid_o, frame_err_o, noise_err_o and irq_o are all 0.
- R2: Frame format. One start bit (0) is followed by data bits, least significant first, and one stop bit. Each bit lasts 16 ticks. With wsel_i=0 there are 8 data bits (10 bits, 160 ticks per frame) and data_o[8] is 0. With wsel_i=1 there are 9 data bits and the ninth bit goes to data_o[8]. Every frame produces exactly one strobe.
- R3: Each bit's value is the majority of samples taken at ticks 8, 9 and 10 of the bit, counting from 1 at the first tick of the bit. A single sample that disagrees does not change the delivered value.
- R4: noise_err_o is 1 for a frame if the three samples of any bit disagree. This covers the start bit, the data bits and the stop bit.
- R5: irq_o equals noise_err_o AND noise_ie_i. When noise_ie_i is 0, the data and noise_err_o are still delivered.
- R6: A frame whose bit edges have drifted by up to 6 ticks at the last data bit, early or late, is decoded correctly with noise_err_o 0.
- R7: If the majority of the start bit's centre samples is 1, the receiver returns to idle without a strobe, and the data and flags it holds are unchanged.
- R8: If the stop bit's majority is 0, frame_err_o is 1 and the data is still delivered.
- R9: valid_o is high for exactly one clock per frame. data_o, frame_err_o and noise_err_o keep their values until the next strobe.
- R10: A new start bit that begins immediately after the 16th tick of the previous stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | One-cycle pulse, 16 per bit period |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| wsel_i | input | 1 | Word length: 0 selects 8 data bits, 1 selects 9 |
| noise_ie_i | input | 1 | Enables the noise interrupt |
| data_o | output | 9 | Received word |
| valid_o | output | 1 | One-cycle strobe when a frame is delivered |
| frame_err_o | output | 1 | Stop bit was read as 0 |
| noise_err_o | output | 1 | Some bit had samples that disagreed |
| irq_o | output | 1 | Noise interrupt request |

## Verification
The bench drives frames tick by tick.

- Clean 8-bit and 9-bit words check bit order and the word-length select.
- Single-tick glitches are placed on the centre sample of the start bit, of a data bit and of the stop bit. These show that the majority vote corrects the value while the noise flag still records the disturbance, and that the enable gates the interrupt.
- Frames with edges six ticks early and six ticks late at the last data bit show the drift tolerance without a false noise flag.
- A short low pulse separates the start-glitch path from a real start.
- A low stop bit exercises the framing error.
- A pair of frames with no gap between them exercises restart directly after the stop bit.

// File: rtl/uart_nrx_pkg.sv
package uart_nrx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    localparam int OVS_DEFAULT  = 16;
    localparam int BITS_DEFAULT = 9;

endpackage

// File: rtl/uart_nrx_sync.sv
module uart_nrx_sync #(
    parameter int    STAGES    = 2,
    parameter logic  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_nrx_vote.sv
module uart_nrx_vote #(
    parameter int CNT_W = 4,
    parameter int FIRST = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             line_i,
    input  logic [CNT_W-1:0] phase_i,
    output logic             done_o,
    output logic             maj_o,
    output logic             noisy_o
);
    localparam logic [CNT_W-1:0] PH_A = CNT_W'(FIRST);
    localparam logic [CNT_W-1:0] PH_B = CNT_W'(FIRST + 1);
    localparam logic [CNT_W-1:0] PH_C = CNT_W'(FIRST + 2);

    logic smp_a, smp_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_a <= 1'b1;
            smp_b <= 1'b1;
        end else if (tick_i) begin
            if (phase_i == PH_A) smp_a <= line_i;
            if (phase_i == PH_B) smp_b <= line_i;
        end
    end

    always_comb begin
        done_o  = tick_i && (phase_i == PH_C);
        maj_o   = (smp_a & smp_b) | (smp_a & line_i) | (smp_b & line_i);
        noisy_o = !((smp_a == smp_b) && (smp_b == line_i));
    end

    // Unanimous samples never report noise.
    AST_VOTE_UNANIMOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && smp_a == line_i && smp_b == line_i) |-> !noisy_o); // R4
endmodule

// File: rtl/uart_nrx.sv
module uart_nrx
    import uart_nrx_pkg::*;
#(
    parameter int OVS         = OVS_DEFAULT,
    parameter int MAX_BITS    = BITS_DEFAULT,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_i,
    input  logic                wsel_i,
    input  logic                noise_ie_i,
    output logic [MAX_BITS-1:0] data_o,
    output logic                valid_o,
    output logic                frame_err_o,
    output logic                noise_err_o,
    output logic                irq_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(MAX_BITS + 1);
    localparam int FIRST_SMP = OVS / 2 - 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(MAX_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(MAX_BITS - 2);

    rx_state_t           state, state_nx;
    logic                rx_s, prev_s;
    logic [CNT_W-1:0]    cnt;
    logic [IDX_W-1:0]    bidx;
    logic [MAX_BITS-1:0] shreg;
    logic                ws_q, noise_acc;
    logic                done, maj, noisy;
    logic                start_edge, last_bit;

    uart_nrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    uart_nrx_vote #(.CNT_W(CNT_W), .FIRST(FIRST_SMP)) u_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (os_tick),
        .line_i  (rx_s),
        .phase_i (cnt),
        .done_o  (done),
        .maj_o   (maj),
        .noisy_o (noisy)
    );

    assign start_edge = os_tick && prev_s && !rx_s;
    assign last_bit   = (bidx == (ws_q ? IDX_LONG : IDX_SHORT));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (start_edge)           state_nx = RX_START;
            RX_START: if (done)                 state_nx = maj ? RX_IDLE : RX_DATA;
            RX_DATA:  if (done && last_bit)     state_nx = RX_STOP;
            RX_STOP:  if (done)                 state_nx = RX_IDLE;
            default:                            state_nx = RX_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_s      <= 1'b1;
            cnt         <= '0;
            bidx        <= '0;
            shreg       <= '0;
            ws_q        <= 1'b0;
            noise_acc   <= 1'b0;
            data_o      <= '0;
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
            noise_err_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (os_tick) begin
                prev_s <= rx_s;
                cnt    <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
            end
            unique case (state)
                RX_IDLE: begin
                    if (start_edge) begin
                        cnt       <= CNT_W'(1);
                        bidx      <= '0;
                        shreg     <= '0;
                        ws_q      <= wsel_i;
                        noise_acc <= 1'b0;
                    end
                end
                RX_START: begin
                    if (done) noise_acc <= noisy;
                end
                RX_DATA: begin
                    if (done) begin
                        shreg[bidx] <= maj;
                        bidx        <= bidx + 1'b1;
                        noise_acc   <= noise_acc | noisy;
                    end
                end
                RX_STOP: begin
                    if (done) begin
                        data_o      <= shreg;
                        frame_err_o <= !maj;
                        noise_err_o <= noise_acc | noisy;
                        valid_o     <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign irq_o = noise_err_o & noise_ie_i;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> ($stable(data_o) && $stable(frame_err_o) && $stable(noise_err_o)) || valid_o); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_ie_i |-> !irq_o); // R5
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_err_o && noise_ie_i) |-> irq_o); // R5
    AST_STROBE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> state == RX_IDLE); // R2
    AST_NINTH_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ws_q) |-> !data_o[MAX_BITS-1]); // R2
endmodule

// File: tb/uart_nrx_test.sv
module uart_nrx_test;
    localparam int CLK_NS   = 10;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_i = 1'b1;
    logic       wsel_i = 1'b0;
    logic       noise_ie_i = 1'b0;
    logic [8:0] data_o;
    logic       valid_o, frame_err_o, noise_err_o, irq_o;

    int errors = 0;
    int checks = 0;
    bit done_run = 0;

    typedef struct {
        logic [8:0] d;
        logic       fe;
        logic       ne;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t q[$];

    uart_nrx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rx_i        (rx_i),
        .wsel_i      (wsel_i),
        .noise_ie_i  (noise_ie_i),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o),
        .noise_err_o (noise_err_o),
        .irq_o       (irq_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk iff os_tick);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        rx_i = 1'b1;
        repeat (n) wait_tick();
    endtask

    // dl: per-bit length change applied to data bits 1..6; gpos: tick that is inverted (-1 none)
    task automatic send(input logic [8:0] d, input logic m9, input logic stopv, input int dl,
                        input int gpos, input logic nie, input int gap, input string tag);
        exp_t e;
        int   nb;
        int   pos;
        logic lv;
        wsel_i     = m9;
        noise_ie_i = nie;
        e.d   = m9 ? d : {1'b0, d[7:0]};
        e.fe  = !stopv;
        e.ne  = (gpos >= 0);
        e.irq = (gpos >= 0) && nie;
        e.tag = tag;
        q.push_back(e);
        nb  = m9 ? 11 : 10;
        pos = 0;
        for (int k = 0; k < nb; k++) begin
            int len;
            if (k == 0)           lv = 1'b0;
            else if (k == nb - 1) lv = stopv;
            else                  lv = d[k-1];
            len = 16 + ((k >= 1 && k <= 6) ? dl : 0);
            for (int j = 0; j < len; j++) begin
                rx_i = (pos == gpos) ? ~lv : lv;
                wait_tick();
                pos++;
            end
        end
        idle(gap);
    endtask

    // Scoreboard monitor
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                if (q.size() == 0) begin
                    chk("R7 unexpected strobe", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({"R2 data ", e.tag}, 32'(data_o), 32'(e.d));
                    chk({"R8 frame_err ", e.tag}, 32'(frame_err_o), 32'(e.fe));
                    chk({"R4 noise_err ", e.tag}, 32'(noise_err_o), 32'(e.ne));
                    chk({"R5 irq ", e.tag}, 32'(irq_o), 32'(e.irq));
                end
            end
            if (prev_valid) chk("R9 strobe width", 32'(valid_o), 32'd0);
            prev_valid <= valid_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 data", 32'(data_o), 32'd0);
        chk("R1 valid", 32'(valid_o), 32'd0);
        chk("R1 frame_err", 32'(frame_err_o), 32'd0);
        chk("R1 noise_err", 32'(noise_err_o), 32'd0);
        chk("R1 irq", 32'(irq_o), 32'd0);
        rst_n = 1'b1;
        idle(8);

        // R2 clean 8-bit and 9-bit words
        send(9'h0A5, 1'b0, 1'b1, 0, -1, 1'b0, 8, "R2 8bit a5");
        send(9'h13C, 1'b0, 1'b1, 0, -1, 1'b0, 8, "R2 8bit 3c");
        send(9'h1B3, 1'b1, 1'b1, 0, -1, 1'b0, 8, "R2 9bit 1b3");
        // R3/R4 glitch on centre sample of data bit 3 (tick 72), enable on and off
        send(9'h05A, 1'b0, 1'b1, 0, 72, 1'b1, 8, "R3 data glitch irq on");
        send(9'h05A, 1'b0, 1'b1, 0, 72, 1'b0, 8, "R5 data glitch irq off");
        // R4 glitch in start bit centre, and in stop bit centre
        send(9'h081, 1'b0, 1'b1, 0, 8, 1'b1, 8, "R4 start glitch");
        send(9'h0F0, 1'b0, 1'b1, 0, 152, 1'b1, 8, "R4 stop glitch");
        // R8 low stop bit
        send(9'h077, 1'b0, 1'b0, 0, -1, 1'b0, 20, "R8 framing");
        // R9 hold after strobe
        chk("R9 data held", 32'(data_o), 32'h077);
        chk("R9 frame_err held", 32'(frame_err_o), 32'd1);
        // R7 short start pulse: no strobe, held results unchanged
        rx_i = 1'b0;
        repeat (4) wait_tick();
        idle(30);
        chk("R7 data unchanged", 32'(data_o), 32'h077);
        chk("R7 frame_err unchanged", 32'(frame_err_o), 32'd1);
        chk("R7 no pending frame", 32'(q.size()), 32'd0);
        // R6 drift six ticks early and six ticks late
        send(9'h0C3, 1'b0, 1'b1, -1, -1, 1'b1, 8, "R6 fast drift");
        send(9'h03D, 1'b0, 1'b1, 1, -1, 1'b1, 8, "R6 slow drift");
        // R10 back-to-back frames
        send(9'h011, 1'b0, 1'b1, 0, -1, 1'b0, 0, "R10 first");
        send(9'h0EE, 1'b0, 1'b1, 0, -1, 1'b0, 0, "R10 second");
        idle(40);
        chk("R2 all frames delivered", 32'(q.size()), 32'd0);

        done_run = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule